// File: doc/BRIEF.md
# Raster Line and Frame Timer

This block turns the master clock into the raster timing of a video frame. Three counters run in step. One counts master clocks within a line. One counts dots, and each dot lasts a fixed number of master clocks. The third counts lines and wraps at the end of the frame. Combinational decode of these counters gives the flags the rest of the chip uses:
- the current line and dot;
- a hidden-line flag for the blank first line;
- a visible-picture flag;
- a vertical-blank flag;
- a one-clock frame-start pulse;
- a field parity bit;
- a window that stalls the processor once in every line.

Three mode inputs are captured only where a frame begins: 50/60 Hz line count, tall or short picture, and interlace. Changing them mid-frame never bends a frame that is in progress. The blanking input is different. It acts on the visible flag in the same clock. Downstream logic reads the flags directly. It uses the frame-start pulse and the parity bit to sequence per-frame and per-field work.

Top module: `raster_timer`

## Requirements
- R1: A line lasts CYC_PER_DOT × DOTS_PER_LINE master clocks (4 × 341 = 1364 by default). The dot output advances once every CYC_PER_DOT clocks and runs 0 to DOTS_PER_LINE−1.
- R2: `cpu_pause` is high for exactly PAUSE_LEN clocks (40) in every line. It starts at line-clock offset PAUSE_START (536).
- R3: On line 0, `hidden_line` is high, and both `visible` and `vblank` are low. On every other line `hidden_line` is low.
- R4: `visible` is high on lines 1 to VIS_SHORT (224), or 1 to VIS_TALL (239) when the captured tall mode is 1. It is forced low in the same clock whenever `force_blank` is 1.
- R5: `vblank` is high from the line after the last visible line through the final line of the frame. It is never high together with `visible`.
- R6: The final line is LAST_LINE_60 (261) when the captured `pal_mode` is 0 and LAST_LINE_50 (311) when it is 1. The next line is line 0.
- R7: When interlace is captured as 1 and `field_odd` is 0, the frame gets one extra line. Its final line is then LAST_LINE_60+1 or LAST_LINE_50+1. Frames with `field_odd` at 1 keep the base length.
- R8: `frame_start` is high for exactly one clock, at line 0, line clock 0. `field_odd` inverts at each frame boundary and changes at no other time.
- R9: `pal_mode`, `tall_mode` and `interlace` are captured only on the clock edge that wraps the line counter to 0. A change at any other time has no effect until the next frame.
- R10: A frame lasts (final line + 1) × line length master clocks: 357368 and 425568 without interlace, and 358732 and 426932 on an interlaced even field, at the default sizes.
- R11: While `rst_n` is low the block holds line 0, dot 0, `field_odd` 0 and `frame_start` 1. The captured modes are 60 Hz, short picture and no interlace.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pal_mode | input | 1 | 1 selects the 50 Hz line count, sampled at frame start |
| tall_mode | input | 1 | 1 selects the taller visible picture, sampled at frame start |
| interlace | input | 1 | 1 adds a line on even fields, sampled at frame start |
| force_blank | input | 1 | 1 blanks the picture immediately |
| line_no | output | LINE_W | Current line number |
| dot_no | output | DOT_W | Current dot within the line |
| visible | output | 1 | Line is part of the shown picture |
| vblank | output | 1 | Vertical blanking interval |
| hidden_line | output | 1 | Blank first line of the frame |
| frame_start | output | 1 | One-clock pulse at the first clock of a frame |
| field_odd | output | 1 | Field parity, inverts every frame |
| cpu_pause | output | 1 | Processor stall window within each line |

## Verification
The bench builds the timer small:
- 2 clocks per dot and 10 dots per line, giving a 20-clock line;
- a 4-clock pause at offset 8;
- 4 or 6 visible lines;
- final lines 9 and 12.

At these sizes a frame takes 200 to 280 clocks. Every clock of dozens of frames can therefore be compared with the line, dot and flag values worked out arithmetically from the position in the frame. The run passes through all four combinations of line count and interlace. It measures the span between frame-start pulses. Mode changes land mid-frame, and the blanking input switches while lines are visible.

// File: rtl/raster_pkg.sv
package raster_pkg;

  // Index of the final line in a frame for the selected line count.
  function automatic int last_line_of(int base_60, int base_50, logic pal, logic extra);
    int base;
    base = pal ? base_50 : base_60;
    return base + (extra ? 1 : 0);
  endfunction

  // Index of the last line that shows picture.
  function automatic int last_visible_of(int short_h, int tall_h, logic tall);
    return tall ? tall_h : short_h;
  endfunction

  // Half-open window test [start, start+len).
  function automatic logic in_window(int v, int start, int len);
    return (v >= start) && (v < start + len);
  endfunction

endpackage

// File: rtl/raster_dot_ctr.sv
module raster_dot_ctr #(
  parameter int CYC_PER_DOT   = 4,
  parameter int DOTS_PER_LINE = 341,
  parameter int CYC_W         = 11,
  parameter int DOT_W         = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [CYC_W-1:0] line_cyc,
  output logic [DOT_W-1:0] dot,
  output logic             line_end
);
  localparam int LINE_CYC = CYC_PER_DOT * DOTS_PER_LINE;
  localparam logic [CYC_W-1:0] CYC_LAST = CYC_W'(LINE_CYC - 1);
  localparam logic [DOT_W-1:0] DOT_LAST = DOT_W'(DOTS_PER_LINE - 1);

  logic dot_step;

  assign line_end = (line_cyc == CYC_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        line_cyc <= '0;
    else if (line_end) line_cyc <= '0;
    else               line_cyc <= line_cyc + CYC_W'(1);
  end

  generate
    if (CYC_PER_DOT == 1) begin : g_one_clk_dot
      assign dot_step = 1'b1;
    end else begin : g_multi_clk_dot
      localparam int SUB_W = $clog2(CYC_PER_DOT);
      localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(CYC_PER_DOT - 1);
      logic [SUB_W-1:0] sub_q;
      assign dot_step = (sub_q == SUB_LAST);
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        sub_q <= '0;
        else if (dot_step) sub_q <= '0;
        else               sub_q <= sub_q + SUB_W'(1);
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             dot <= '0;
    else if (dot_step) begin
      if (dot == DOT_LAST)  dot <= '0;
      else                  dot <= dot + DOT_W'(1);
    end
  end

endmodule

// File: rtl/raster_line_ctr.sv
module raster_line_ctr
  import raster_pkg::*;
#(
  parameter int LAST_LINE_60 = 261,
  parameter int LAST_LINE_50 = 311,
  parameter int LINE_W       = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_end,
  input  logic              pal_in,
  input  logic              tall_in,
  input  logic              ilace_in,
  output logic [LINE_W-1:0] line,
  output logic              field_odd,
  output logic              cfg_tall,
  output logic              frame_wrap
);
  logic cfg_pal, cfg_ilace;
  logic extra_line;
  logic [LINE_W-1:0] final_line;

  assign extra_line = cfg_ilace & ~field_odd;
  assign final_line = LINE_W'(last_line_of(LAST_LINE_60, LAST_LINE_50, cfg_pal, extra_line));
  assign frame_wrap = line_end && (line == final_line);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          line <= '0;
    else if (frame_wrap) line <= '0;
    else if (line_end)   line <= line + LINE_W'(1);
  end

  // Field parity and mode capture happen only at the frame boundary.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      field_odd <= 1'b0;
      cfg_pal   <= 1'b0;
      cfg_tall  <= 1'b0;
      cfg_ilace <= 1'b0;
    end else if (frame_wrap) begin
      field_odd <= ~field_odd;
      cfg_pal   <= pal_in;
      cfg_tall  <= tall_in;
      cfg_ilace <= ilace_in;
    end
  end

endmodule

// File: rtl/raster_decode.sv
module raster_decode
  import raster_pkg::*;
#(
  parameter int VIS_SHORT   = 224,
  parameter int VIS_TALL    = 239,
  parameter int PAUSE_START = 536,
  parameter int PAUSE_LEN   = 40,
  parameter int CYC_W       = 11,
  parameter int LINE_W      = 9
) (
  input  logic [LINE_W-1:0] line,
  input  logic [CYC_W-1:0]  line_cyc,
  input  logic              cfg_tall,
  input  logic              force_blank,
  output logic              hidden_line,
  output logic              visible,
  output logic              vblank,
  output logic              frame_start,
  output logic              cpu_pause
);
  int last_vis;

  always_comb begin
    last_vis    = last_visible_of(VIS_SHORT, VIS_TALL, cfg_tall);
    hidden_line = (line == '0);
    visible     = !hidden_line && (int'(line) <= last_vis) && !force_blank;
    vblank      = int'(line) > last_vis;
    frame_start = hidden_line && (line_cyc == '0);
    cpu_pause   = in_window(int'(line_cyc), PAUSE_START, PAUSE_LEN);
  end

endmodule

// File: rtl/raster_timer.sv
module raster_timer #(
  parameter int CYC_PER_DOT   = 4,
  parameter int DOTS_PER_LINE = 341,
  parameter int PAUSE_START   = 536,
  parameter int PAUSE_LEN     = 40,
  parameter int VIS_SHORT     = 224,
  parameter int VIS_TALL      = 239,
  parameter int LAST_LINE_60  = 261,
  parameter int LAST_LINE_50  = 311,
  localparam int LINE_CYC     = CYC_PER_DOT * DOTS_PER_LINE,
  localparam int CYC_W        = $clog2(LINE_CYC),
  localparam int DOT_W        = $clog2(DOTS_PER_LINE),
  localparam int LINE_W       = $clog2(LAST_LINE_50 + 2)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pal_mode,
  input  logic              tall_mode,
  input  logic              interlace,
  input  logic              force_blank,
  output logic [LINE_W-1:0] line_no,
  output logic [DOT_W-1:0]  dot_no,
  output logic              visible,
  output logic              vblank,
  output logic              hidden_line,
  output logic              frame_start,
  output logic              field_odd,
  output logic              cpu_pause
);
  // Internal events brought out by name for the checker.
  logic [CYC_W-1:0] line_cyc;
  logic             line_end;
  logic             frame_wrap;
  logic             cfg_tall;

  raster_dot_ctr #(
    .CYC_PER_DOT(CYC_PER_DOT), .DOTS_PER_LINE(DOTS_PER_LINE),
    .CYC_W(CYC_W), .DOT_W(DOT_W)
  ) dot_ctr_i (
    .clk(clk), .rst_n(rst_n),
    .line_cyc(line_cyc), .dot(dot_no), .line_end(line_end)
  );

  raster_line_ctr #(
    .LAST_LINE_60(LAST_LINE_60), .LAST_LINE_50(LAST_LINE_50), .LINE_W(LINE_W)
  ) line_ctr_i (
    .clk(clk), .rst_n(rst_n), .line_end(line_end),
    .pal_in(pal_mode), .tall_in(tall_mode), .ilace_in(interlace),
    .line(line_no), .field_odd(field_odd), .cfg_tall(cfg_tall),
    .frame_wrap(frame_wrap)
  );

  raster_decode #(
    .VIS_SHORT(VIS_SHORT), .VIS_TALL(VIS_TALL),
    .PAUSE_START(PAUSE_START), .PAUSE_LEN(PAUSE_LEN),
    .CYC_W(CYC_W), .LINE_W(LINE_W)
  ) decode_i (
    .line(line_no), .line_cyc(line_cyc), .cfg_tall(cfg_tall),
    .force_blank(force_blank),
    .hidden_line(hidden_line), .visible(visible), .vblank(vblank),
    .frame_start(frame_start), .cpu_pause(cpu_pause)
  );

endmodule

// File: rtl/raster_timer_chk.sv
module raster_timer_chk #(
  parameter int CYC_PER_DOT  = 4,
  parameter int PAUSE_START  = 536,
  parameter int PAUSE_LEN    = 40,
  parameter int LAST_LINE_60 = 261,
  parameter int LAST_LINE_50 = 311,
  parameter int CYC_W        = 11,
  parameter int DOT_W        = 9,
  parameter int LINE_W       = 9
) (
  input logic              clk,
  input logic              rst_n,
  input logic [LINE_W-1:0] line_no,
  input logic [DOT_W-1:0]  dot_no,
  input logic [CYC_W-1:0]  line_cyc,
  input logic              frame_wrap,
  input logic              visible,
  input logic              vblank,
  input logic              hidden_line,
  input logic              frame_start,
  input logic              field_odd,
  input logic              cpu_pause
);
  // R1: dot counter and line-clock counter stay in step
  p_dot_in_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(dot_no) * CYC_PER_DOT <= int'(line_cyc)) &&
    (int'(line_cyc) < (int'(dot_no) + 1) * CYC_PER_DOT));

  // R2: stall window opens and closes at fixed offsets
  p_pause_open_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cpu_pause) |-> int'(line_cyc) == PAUSE_START);
  p_pause_close_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cpu_pause) |-> int'(line_cyc) == PAUSE_START + PAUSE_LEN);

  // R3: first line is blank
  p_line0_blank_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (line_no == '0) |-> (hidden_line && !visible && !vblank));

  // R5: picture and blanking never overlap
  p_vis_vbl_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(visible && vblank));

  // R6: line moves only at the start of a line; wrap only from a legal final line
  p_line_moves_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (line_no != $past(line_no)) |-> (line_cyc == '0));
  p_wrap_line_r6: assert property (@(posedge clk) disable iff (!rst_n)
    frame_wrap |-> (int'(line_no) == LAST_LINE_60 || int'(line_no) == LAST_LINE_60 + 1 ||
                    int'(line_no) == LAST_LINE_50 || int'(line_no) == LAST_LINE_50 + 1));

  // R7: odd fields never carry the extra line
  p_odd_base_len_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_wrap && field_odd) |-> (int'(line_no) == LAST_LINE_60 || int'(line_no) == LAST_LINE_50));

  // R8: single-clock pulse; parity changes only into a frame start
  p_fs_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> !frame_start);
  p_field_at_fs_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (field_odd != $past(field_odd)) |-> frame_start);

endmodule

bind raster_timer raster_timer_chk #(
  .CYC_PER_DOT(CYC_PER_DOT), .PAUSE_START(PAUSE_START), .PAUSE_LEN(PAUSE_LEN),
  .LAST_LINE_60(LAST_LINE_60), .LAST_LINE_50(LAST_LINE_50),
  .CYC_W(CYC_W), .DOT_W(DOT_W), .LINE_W(LINE_W)
) chk_i (
  .clk(clk), .rst_n(rst_n), .line_no(line_no), .dot_no(dot_no),
  .line_cyc(line_cyc), .frame_wrap(frame_wrap), .visible(visible),
  .vblank(vblank), .hidden_line(hidden_line), .frame_start(frame_start),
  .field_odd(field_odd), .cpu_pause(cpu_pause)
);

// File: tb/raster_timer_tb_top.sv
module raster_timer_tb_top;
  localparam int CPD = 2, DPL = 10, PS = 8, PL = 4;
  localparam int VS = 4, VT = 6, LN = 9, LP = 12;
  localparam int LC = CPD * DPL;
  localparam int LW = $clog2(LP + 2);
  localparam int DW = $clog2(DPL);

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, pal_mode, tall_mode, interlace, force_blank;
  logic [LW-1:0] line_no;
  logic [DW-1:0] dot_no;
  logic visible, vblank, hidden_line, frame_start, field_odd, cpu_pause;

  raster_timer #(
    .CYC_PER_DOT(CPD), .DOTS_PER_LINE(DPL), .PAUSE_START(PS), .PAUSE_LEN(PL),
    .VIS_SHORT(VS), .VIS_TALL(VT), .LAST_LINE_60(LN), .LAST_LINE_50(LP)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .pal_mode(pal_mode), .tall_mode(tall_mode),
    .interlace(interlace), .force_blank(force_blank),
    .line_no(line_no), .dot_no(dot_no), .visible(visible), .vblank(vblank),
    .hidden_line(hidden_line), .frame_start(frame_start),
    .field_odd(field_odd), .cpu_pause(cpu_pause)
  );

  int n_chk = 0, n_bad = 0;
  int pos = 0;            // model position within the frame
  bit par = 0;            // model field parity
  bit c_pal = 0, c_tall = 0, c_il = 0;  // model captured modes (R11 defaults)
  int since_fs = 0, last_len = 0, combo_mask = 0;
  bit seen_fs = 0;

  task automatic chk(string tag, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: got %0d expected %0d (frame pos %0d)", tag, what, act, exp, pos);
    end
  endtask

  function automatic int frame_len();
    return ((c_pal ? LP : LN) + 1 + ((c_il && !par) ? 1 : 0)) * LC;
  endfunction

  task automatic step(string tag);
    int ln, cy, lv;
    ln = pos / LC;
    cy = pos % LC;
    lv = c_tall ? VT : VS;
    chk(tag,  "line",        int'(line_no), ln);
    chk("R1", "dot",         int'(dot_no), cy / CPD);
    chk("R2", "cpu_pause",   int'(cpu_pause), int'(cy >= PS && cy < PS + PL));
    chk("R3", "hidden_line", int'(hidden_line), int'(ln == 0));
    chk("R4", "visible",     int'(visible), int'(ln >= 1 && ln <= lv && !force_blank));
    chk("R5", "vblank",      int'(vblank), int'(ln > lv));
    chk("R8", "frame_start", int'(frame_start), int'(pos == 0));
    chk("R8", "field_odd",   int'(field_odd), int'(par));
    if (frame_start) begin
      if (seen_fs) chk("R10", "frame_len", since_fs, last_len);
      seen_fs = 1;
      since_fs = 0;
    end
    since_fs++;
    pos++;
    if (pos == frame_len()) begin
      last_len = frame_len();
      combo_mask |= 1 << {c_pal, c_il};
      pos = 0;
      par = ~par;
      // R9: modes taken from the inputs only at this wrap
      c_pal = pal_mode; c_tall = tall_mode; c_il = interlace;
    end
    @(negedge clk);
  endtask

  task automatic run_phase(string tag, bit p, bit t, bit il, bit fb, int ncyc);
    pal_mode = p; tall_mode = t; interlace = il; force_blank = fb;
    for (int i = 0; i < ncyc; i++) step(tag);
  endtask

  initial begin
    rst_n = 1'b0; pal_mode = 0; tall_mode = 0; interlace = 0; force_blank = 0;
    repeat (3) @(negedge clk);
    chk("R11", "reset line",        int'(line_no), 0);
    chk("R11", "reset dot",         int'(dot_no), 0);
    chk("R11", "reset field_odd",   int'(field_odd), 0);
    chk("R11", "reset frame_start", int'(frame_start), 1);
    rst_n = 1'b1;
    run_phase("R6", 0, 0, 0, 0, 450);
    run_phase("R9", 1, 1, 0, 0, 700);   // lands mid-frame
    run_phase("R7", 1, 0, 1, 0, 1300);
    run_phase("R7", 0, 1, 1, 0, 1000);
    run_phase("R4", 0, 0, 0, 1, 500);
    run_phase("R9", 1, 0, 1, 1, 137);
    run_phase("R4", 1, 0, 1, 0, 63);
    run_phase("R6", 0, 1, 0, 0, 900);
    chk("R10", "all four mode combinations measured", combo_mask, 15);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run did not finish, got 0 expected 1");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule